// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Service

A memory-mapped watchdog on a plain 32-bit register bus. Software arms it once with a 32-bit key. From then on, a down-counter starts at the programmed timeout and counts down one per clock. Software must service it with an ordered pair of 16-bit keys.

A service counts only when it completes inside an open window at the end of the period. The window is a programmable fraction of the period. Completing the service too early is a violation. So is writing an unexpected key, leaving the counter to reach zero, or selecting an undefined window code while armed.

A violation sets a sticky status flag. It also emits a one-cycle pulse on either an interrupt-style output or a reset-style output, chosen by a reaction register. Arming cannot be undone except by reset. Bus reads are combinational on the address; writes take effect at the clock edge in which the write strobe is high.

Top module: `window_watchdog`

## Requirements
- R1: After reset the control register reads 0 (disarmed), the status register reads 0, the counter (offset 0x10) reads 0, and both reaction outputs are low.
- R2: Only a write of 0xA98559DA to the control register (offset 0x00) arms the block; any other value leaves it disarmed; bit 0 of the control register reads the armed state.
- R3: The timeout register (offset 0x04) keeps only its low 12 bits; arming, or a valid service, loads the counter with that value shifted left by 13.
- R4: While armed and above zero, the counter decreases by exactly one per clock.
- R5: A service is a write of 0xE51A followed by a write of 0xA35C to the key register (offset 0x0C); when the second key is written while the counter is at or below the window threshold, the counter reloads and no violation occurs.
- R6: If the second key is written while the counter is above the window threshold, a violation occurs and the counter is not reloaded.
- R7: While armed, a key write that is not the expected next key is a violation; while disarmed, key writes have no effect.
- R8: The counter reaching zero while armed is a violation; the counter then stays at zero.
- R9: The window register (offset 0x18, reset value 0x5) takes the codes 0x5, 0x50, 0x500, 0x5000, 0x50000 and 0x500000, which set the threshold to the reload value shifted right by 0 to 5 places in that order; any other code is a violation while armed and has no effect while disarmed.
- R10: Once armed, the block stays armed until reset; later control writes neither disarm it nor reload the counter.
- R11: Bit 1 of the status register (offset 0x08) is a sticky violation flag, cleared by writing 1 to bit 1; writing 0 there has no effect; a violation in the same cycle as a clear keeps the flag set.
- R12: When the reaction register (offset 0x14, reset 0) holds 0xA, a violation drives irq_pulse; with any other value it drives rst_pulse. The pulse is high for one cycle, in the cycle after the violation begins, and only if the flag was clear.
- R13: Writing 0xE51A again while the first key is pending keeps the service pending, and a following 0xA35C completes it normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-cycle interrupt-style violation pulse |
| rst_pulse | output | 1 | One-cycle reset-style violation pulse |

## Verification
Every cycle, the assertions check several rules. The armed state never falls, and it only rises after the arming key. The counter steps down by one unless it is loading. A load from a service equals the shifted timeout. A zero count while armed sets the flag. The two pulses are exclusive and last one cycle, and they only occur together with the flag. Whether a service lands on the correct side of the window edge can only be shown by the bench scenarios: at the 50% threshold, completion one count above the edge fails and completion at the edge passes. The same holds for the choice of output by the reaction code, the write-one-to-clear behaviour, and the effect of undefined window codes.

// File: rtl/wwdg_pkg.sv
`timescale 1ns/1ps
package wwdg_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_PRE   = 5'h04;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 5'h08;
  localparam logic [ADDR_W-1:0] ADDR_KEY   = 5'h0C;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_REACT = 5'h14;
  localparam logic [ADDR_W-1:0] ADDR_WIN   = 5'h18;

  localparam logic [31:0] ARM_KEY    = 32'hA98559DA;
  localparam logic [31:0] KEY_OPEN   = 32'h0000E51A;
  localparam logic [31:0] KEY_CLOSE  = 32'h0000A35C;
  localparam logic [31:0] REACT_IRQ  = 32'h0000000A;
  localparam logic [31:0] WIN_RESET  = 32'h00000005;
  localparam int          STAT_BIT   = 1;

  typedef enum logic {SVC_IDLE, SVC_PENDING} svc_state_t;

  typedef struct packed {
    logic       ok;
    logic [2:0] div;
  } win_sel_t;

  function automatic win_sel_t decode_window(input logic [31:0] code);
    win_sel_t s;
    s.ok  = 1'b1;
    s.div = 3'd0;
    case (code)
      32'h00000005: s.div = 3'd0;
      32'h00000050: s.div = 3'd1;
      32'h00000500: s.div = 3'd2;
      32'h00005000: s.div = 3'd3;
      32'h00050000: s.div = 3'd4;
      32'h00500000: s.div = 3'd5;
      default:      s.ok  = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/wwdg_counter.sv
`timescale 1ns/1ps
module wwdg_counter #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wwdg_window.sv
`timescale 1ns/1ps
module wwdg_window
  import wwdg_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] reload,
  input  logic [31:0]      code,
  output logic             in_window,
  output logic             code_ok
);
  win_sel_t         sel;
  logic [CNT_W-1:0] thresh;

  always_comb begin
    sel       = decode_window(code);
    thresh    = reload >> sel.div;
    in_window = (count <= thresh);
    code_ok   = sel.ok;
  end
endmodule

// File: rtl/wwdg_keyseq.sv
`timescale 1ns/1ps
module wwdg_keyseq
  import wwdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  input  logic        in_window,
  output logic        done_o,
  output logic        bad_o
);
  svc_state_t st_q, st_d;

  always_comb begin
    st_d   = st_q;
    done_o = 1'b0;
    bad_o  = 1'b0;
    if (armed && key_wr) begin
      case (st_q)
        SVC_IDLE: begin
          if (key_val == KEY_OPEN) st_d = SVC_PENDING;
          else                     bad_o = 1'b1;
        end
        SVC_PENDING: begin
          if (key_val == KEY_OPEN) begin
            st_d = SVC_PENDING;
          end else if (key_val == KEY_CLOSE) begin
            st_d = SVC_IDLE;
            if (in_window) done_o = 1'b1;
            else           bad_o  = 1'b1;
          end else begin
            st_d  = SVC_IDLE;
            bad_o = 1'b1;
          end
        end
        default: st_d = SVC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SVC_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/window_watchdog.sv
`timescale 1ns/1ps
module window_watchdog
  import wwdg_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_pulse,
  output logic              rst_pulse
);
  localparam int CNT_W = PRE_W + SHIFT;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic             armed_q, armed_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [31:0]      react_q, react_d, win_q, win_d;
  logic             flag_q, flag_d;
  logic             irq_q, irq_d, rstp_q, rstp_d;

  logic             ctrl_wr, pre_wr, stat_wr, key_wr, react_wr, win_wr;
  logic             arm_now, cnt_load, svc_done, svc_bad;
  logic             in_win, win_ok, viol, pulse_new;
  logic [CNT_W-1:0] cnt, reload_val;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
  assign pre_wr   = bus_wr && (bus_addr == ADDR_PRE);
  assign stat_wr  = bus_wr && (bus_addr == ADDR_STAT);
  assign key_wr   = bus_wr && (bus_addr == ADDR_KEY);
  assign react_wr = bus_wr && (bus_addr == ADDR_REACT);
  assign win_wr   = bus_wr && (bus_addr == ADDR_WIN);

  assign reload_val = CNT_W'(pre_q) << SHIFT;
  assign arm_now    = ctrl_wr && !armed_q && (bus_wdata == ARM_KEY);
  assign cnt_load   = arm_now || svc_done;

  wwdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (armed_q),
    .load     (cnt_load),
    .load_val (reload_val),
    .count_o  (cnt)
  );

  wwdg_window #(.CNT_W(CNT_W)) u_win (
    .count     (cnt),
    .reload    (reload_val),
    .code      (win_q),
    .in_window (in_win),
    .code_ok   (win_ok)
  );

  wwdg_keyseq u_key (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .armed     (armed_q),
    .key_wr    (key_wr),
    .key_val   (bus_wdata),
    .in_window (in_win),
    .done_o    (svc_done),
    .bad_o     (svc_bad)
  );

  assign viol      = armed_q && (svc_bad || (cnt == '0) || !win_ok);
  assign pulse_new = viol && !flag_q;

  always_comb begin
    armed_d = armed_q || arm_now;
    pre_d   = pre_wr   ? bus_wdata[PRE_W-1:0] : pre_q;
    react_d = react_wr ? bus_wdata : react_q;
    win_d   = win_wr   ? bus_wdata : win_q;
    flag_d  = flag_q;
    if (stat_wr && bus_wdata[STAT_BIT]) flag_d = 1'b0;
    if (viol)                           flag_d = 1'b1;
    irq_d   = pulse_new && (react_q == REACT_IRQ);
    rstp_d  = pulse_new && (react_q != REACT_IRQ);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      armed_q <= 1'b0;
      pre_q   <= '0;
      react_q <= '0;
      win_q   <= WIN_RESET;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      rstp_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pre_q   <= pre_d;
      react_q <= react_d;
      win_q   <= win_d;
      flag_q  <= flag_d;
      irq_q   <= irq_d;
      rstp_q  <= rstp_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL:  bus_rdata[0]        = armed_q;
      ADDR_PRE:   bus_rdata           = 32'(pre_q);
      ADDR_STAT:  bus_rdata[STAT_BIT] = flag_q;
      ADDR_CNT:   bus_rdata           = 32'(cnt);
      ADDR_REACT: bus_rdata           = react_q;
      ADDR_WIN:   bus_rdata           = win_q;
      default:    bus_rdata           = '0;
    endcase
  end

  assign irq_pulse = irq_q;
  assign rst_pulse = rstp_q;
endmodule

// File: rtl/wwdg_checker.sv
`timescale 1ns/1ps
module wwdg_checker
  import wwdg_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int SHIFT = 13,
  parameter int CNT_W = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              armed,
  input logic [CNT_W-1:0]  cnt,
  input logic              load,
  input logic              done,
  input logic              flag,
  input logic              irq,
  input logic              rstp,
  input logic [PRE_W-1:0]  pre,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata
);
  assert_arm_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr && (addr == ADDR_CTRL) && (wdata == ARM_KEY)));

  assert_arm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (cnt != '0) && !load) |=> (cnt == $past(cnt) - 1'b1));

  assert_service_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt == (CNT_W'($past(pre)) << SHIFT)));

  assert_expiry_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (cnt == '0)) |=> flag);

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, rstp}));

  assert_irq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_rst_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rstp |=> !rstp);

  assert_pulse_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || rstp) |-> flag);
endmodule

bind window_watchdog wwdg_checker #(.PRE_W(PRE_W), .SHIFT(SHIFT), .CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .armed (armed_q),
  .cnt   (cnt),
  .load  (cnt_load),
  .done  (svc_done),
  .flag  (flag_q),
  .irq   (irq_q),
  .rstp  (rstp_q),
  .pre   (pre_q),
  .wr    (bus_wr),
  .addr  (bus_addr),
  .wdata (bus_wdata)
);

// File: tb/window_watchdog_bench.sv
`timescale 1ns/1ps
module window_watchdog_bench;
  import wwdg_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_pulse, rst_pulse;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int irq_n  = 0;
  int rst_n_cnt = 0;

  window_watchdog u_window_watchdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse),
    .rst_pulse (rst_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  always @(negedge clk) begin
    if (irq_pulse) irq_n++;
    if (rst_pulse) rst_n_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // {addr, write data, expected read-back}
  localparam logic [68:0] TBL [9] = '{
    {ADDR_CTRL,  32'h12345678, 32'h0},      // R2 wrong key stays disarmed
    {ADDR_PRE,   32'h00000FFF, 32'hFFF},    // R3
    {ADDR_PRE,   32'h00001234, 32'h234},    // R3 only 12 bits kept
    {ADDR_REACT, 32'h0000000A, 32'hA},      // R12
    {ADDR_REACT, 32'h00000003, 32'h3},      // R12
    {ADDR_WIN,   32'h00000500, 32'h500},    // R9
    {ADDR_WIN,   32'h00000005, 32'h5},      // R9
    {ADDR_CTRL,  ARM_KEY,      32'h1},      // R2 arms
    {ADDR_CTRL,  32'h00000000, 32'h1}       // R10 cannot disarm
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_count(input logic [31:0] target);
    logic [31:0] d;
    rd(ADDR_CNT, d);
    while (d != target) begin
      @(negedge clk);
      rd(ADDR_CNT, d);
    end
  endtask

  task automatic arm_one();
    wr(ADDR_PRE, 32'h1);
    wr(ADDR_CTRL, ARM_KEY);
  endtask

  initial begin
    logic [31:0] d;
    int base;
    rst_n = 1'b0;
    do_reset();

    // R1 reset state
    rd(ADDR_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(ADDR_STAT, d); chk("R1 status", d, 32'h0);
    rd(ADDR_CNT, d);  chk("R1 count", d, 32'h0);
    chk("R1 pulses", {30'b0, irq_pulse, rst_pulse}, 32'h0);
    rd(ADDR_WIN, d);  chk("R9 window reset", d, WIN_RESET);

    // R7 key writes while disarmed are ignored
    wr(ADDR_KEY, 32'h1111);
    rd(ADDR_STAT, d); chk("R7 disarmed key ignored", d, 32'h0);

    // R9 undefined window code harmless while disarmed
    wr(ADDR_WIN, 32'h7);
    repeat (4) @(negedge clk);
    rd(ADDR_STAT, d); chk("R9 bad code disarmed", d, 32'h0);

    // register table walk
    for (int i = 0; i < 9; i++) begin
      wr(TBL[i][68:64], TBL[i][63:32]);
      rd(TBL[i][68:64], d);
      if (d !== TBL[i][31:0]) begin
        checks++; errors++;
        $display("FAIL table[%0d] R2/R3/R9/R10/R12: actual 0x%0h expected 0x%0h", i, d, TBL[i][31:0]);
      end else checks++;
    end

    // R3 load and R4 countdown; R10 re-arm does not reload
    do_reset();
    arm_one();
    rd(ADDR_CNT, d); chk("R3 reload", d, 32'h2000);
    repeat (100) @(negedge clk);
    rd(ADDR_CNT, d); chk("R4 countdown", d, 32'h2000 - 100);
    wr(ADDR_CTRL, ARM_KEY);
    rd(ADDR_CNT, d); chk("R10 no reload on rearm", d, 32'h2000 - 101);

    // R6 early service with default 100% window is fine -> use 50%
    do_reset();
    wr(ADDR_WIN, 32'h50);
    arm_one();
    base = rst_n_cnt;
    wr(ADDR_KEY, KEY_OPEN);
    wr(ADDR_KEY, KEY_CLOSE);
    rd(ADDR_STAT, d); chk("R6 early flag", d, 32'h2);
    chk("R12 rst pulse high", {31'b0, rst_pulse}, 32'h1);
    rd(ADDR_CNT, d); chk("R6 no reload", d, 32'h2000 - 2);
    @(negedge clk);
    chk("R12 pulse one cycle", {31'b0, rst_pulse}, 32'h0);
    chk("R12 rst pulse count", rst_n_cnt - base, 1);
    // R11 write-one-to-clear
    wr(ADDR_STAT, 32'h0);
    rd(ADDR_STAT, d); chk("R11 write 0 keeps", d, 32'h2);
    wr(ADDR_STAT, 32'h2);
    rd(ADDR_STAT, d); chk("R11 write 1 clears", d, 32'h0);

    // R6 boundary: one count above threshold 4096
    do_reset();
    wr(ADDR_WIN, 32'h50);
    arm_one();
    wr(ADDR_KEY, KEY_OPEN);
    wait_count(32'd4097);
    wr(ADDR_KEY, KEY_CLOSE);
    rd(ADDR_STAT, d); chk("R6 edge+1 flag", d, 32'h2);
    rd(ADDR_CNT, d);  chk("R6 edge+1 no reload", d, 32'd4096);

    // R5 and R13: at threshold with repeated first key
    do_reset();
    wr(ADDR_WIN, 32'h50);
    arm_one();
    wr(ADDR_KEY, KEY_OPEN);
    wr(ADDR_KEY, KEY_OPEN);
    wait_count(32'd4096);
    wr(ADDR_KEY, KEY_CLOSE);
    rd(ADDR_STAT, d); chk("R5 R13 in window no flag", d, 32'h0);
    rd(ADDR_CNT, d);  chk("R5 reload", d, 32'h2000);

    // R7 wrong key while armed, R12 interrupt selection
    wr(ADDR_REACT, REACT_IRQ);
    base = irq_n;
    wr(ADDR_KEY, 32'h1234);
    rd(ADDR_STAT, d); chk("R7 wrong key flag", d, 32'h2);
    chk("R12 irq pulse", {30'b0, irq_pulse, rst_pulse}, 32'h2);
    @(negedge clk);
    chk("R12 irq count", irq_n - base, 1);

    // R9 100% window accepts immediate service; 25% threshold 2048
    do_reset();
    arm_one();
    wr(ADDR_KEY, KEY_OPEN);
    wr(ADDR_KEY, KEY_CLOSE);
    rd(ADDR_STAT, d); chk("R9 full window ok", d, 32'h0);
    rd(ADDR_CNT, d);  chk("R9 full window reload", d, 32'h2000);
    wr(ADDR_WIN, 32'h500);
    wr(ADDR_KEY, KEY_OPEN);
    wait_count(32'd2049);
    wr(ADDR_KEY, KEY_CLOSE);
    rd(ADDR_STAT, d); chk("R9 quarter window edge+1", d, 32'h2);

    // R9 undefined code while armed
    do_reset();
    arm_one();
    wr(ADDR_WIN, 32'h7);
    @(negedge clk);
    rd(ADDR_STAT, d); chk("R9 bad code armed", d, 32'h2);

    // R8 expiry
    do_reset();
    arm_one();
    base = rst_n_cnt;
    repeat (8300) @(negedge clk);
    rd(ADDR_CNT, d);  chk("R8 count held at 0", d, 32'h0);
    rd(ADDR_STAT, d); chk("R8 expiry flag", d, 32'h2);
    chk("R12 single pulse on expiry", rst_n_cnt - base, 1);
    // R11 violation persisting beats clear
    wr(ADDR_STAT, 32'h2);
    @(negedge clk);
    rd(ADDR_STAT, d); chk("R11 persistent violation", d, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule